// File: doc/BRIEF.md
# Two-Level Carry Lookahead Adder

This block is a purely combinational 16-bit adder. It takes two operands and a carry-in and returns the 16-bit sum and the carry-out. It contains no registers. The word is split into four 4-bit groups, bits 0–3, 4–7, 8–11 and 12–15.

Each group works out a generate bit (AND of the two operand bits) and a propagate bit (inclusive OR of the two operand bits) for every position. Inside the group, each carry is a flattened sum-of-products over those bits and the group carry-in, so no carry waits for the carry of the position below it. Each group also reports a group generate and a group propagate.

A second-level unit applies the same flattened form to the four group pairs. It produces the group carry-ins c4, c8 and c12 and the final carry c16. It also produces a word-wide generate and propagate pair, so that four of these adders can be joined under one more lookahead level.

Top module: `cla16_adder`

## Requirements
- R1: `sum` equals the low 16 bits of `op_a + op_b + carry_in`, for every operand pair and both carry-in values.
- R2: `carry_out` equals bit 16 of the 17-bit result `op_a + op_b + carry_in`.
- R3: `word_gen` is 1 exactly when `op_a + op_b` with carry-in 0 overflows 16 bits. Its value does not depend on `carry_in`.
- R4: `word_prop` is 1 exactly when every one of the 16 bit positions has at least one operand bit set, that is, when `(op_a | op_b)` equals 0xFFFF.
- R5: whenever `word_gen` is 1, `carry_out` is 1 whatever the value of `carry_in`.
- R6: whenever `word_gen` is 0 and `word_prop` is 1, `carry_out` equals `carry_in`.
- R7: a carry-in of 1 with `op_a` = 0xFFFF and `op_b` = 0 travels through all four groups, giving `sum` = 0x0000 and `carry_out` = 1.
- R8: a carry created in one group reaches the next group through the second-level unit. For example, 0x000F + 0x0001 gives 0x0010, and 0x0FFF + 0x0001 gives 0x1000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| carry_out | output | 1 | Carry out of bit 15 |
| word_gen | output | 1 | Word-level generate, for cascading |
| word_prop | output | 1 | Word-level propagate, for cascading |

## Verification
Random operands almost never hit the case where every position propagates and a single carry-in must cross all four groups and the second-level unit. The bench therefore builds that case on purpose. It uses all-ones against zero, and complementary pairs such as 0xA5A5 against 0x5A5A, with both carry-in values. It also uses a walking single-group carry, where one group generates and the groups above only propagate. This separates the second-level carry terms from the in-group ones.

// File: rtl/cla16_pkg.sv
package cla16_pkg;

    localparam int GRP_W  = 4;
    localparam int GRP_N  = 4;
    localparam int WORD_W = GRP_W * GRP_N;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic gen;
        logic prop;
    } gp_t;

    function automatic logic sum_bit(input logic x, input logic y, input logic c);
        return x ^ y ^ c;
    endfunction

endpackage

// File: rtl/cla16_lookahead.sv
module cla16_lookahead
    import cla16_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0] g_vec,
    input  logic [N-1:0] p_vec,
    input  logic         c_in,
    output logic [N-1:1] c_mid,
    output gp_t          blk
);

    // Carry into position top+1, written as one flattened sum of products:
    // each generate term is gated by the propagates above it,
    // and the carry-in is gated by every propagate.
    function automatic logic carry_at(input logic [N-1:0] g, input logic [N-1:0] p,
                                      input int top, input logic ci);
        logic acc;
        logic term;
        acc = 1'b0;
        for (int j = 0; j <= top; j++) begin
            term = g[j];
            for (int k = j + 1; k <= top; k++) term = term & p[k];
            acc = acc | term;
        end
        term = ci;
        for (int k = 0; k <= top; k++) term = term & p[k];
        return acc | term;
    endfunction

    for (genvar i = 1; i < N; i++) begin : g_carry
        assign c_mid[i] = carry_at(g_vec, p_vec, i - 1, c_in);
    end

    assign blk.gen  = carry_at(g_vec, p_vec, N - 1, 1'b0);
    assign blk.prop = &p_vec;

endmodule

// File: rtl/cla16_group.sv
module cla16_group
    import cla16_pkg::*;
(
    input  logic [GRP_W-1:0] a_sl,
    input  logic [GRP_W-1:0] b_sl,
    input  logic             c_in,
    output logic [GRP_W-1:0] s_sl,
    output gp_t              grp
);

    logic [GRP_W-1:0] bit_g;
    logic [GRP_W-1:0] bit_p;
    logic [GRP_W-1:0] c_vec;
    logic [GRP_W-1:1] c_mid;

    assign bit_g = a_sl & b_sl;
    assign bit_p = a_sl | b_sl;

    cla16_lookahead #(.N(GRP_W)) i_la (
        .g_vec (bit_g),
        .p_vec (bit_p),
        .c_in  (c_in),
        .c_mid (c_mid),
        .blk   (grp)
    );

    assign c_vec[0]         = c_in;
    assign c_vec[GRP_W-1:1] = c_mid;

    for (genvar i = 0; i < GRP_W; i++) begin : g_sum
        assign s_sl[i] = sum_bit(a_sl[i], b_sl[i], c_vec[i]);
    end

endmodule

// File: rtl/cla16_adder.sv
module cla16_adder
    import cla16_pkg::*;
(
    input  logic [15:0] op_a,
    input  logic [15:0] op_b,
    input  logic        carry_in,
    output logic [15:0] sum,
    output logic        carry_out,
    output logic        word_gen,
    output logic        word_prop
);

    gp_t              grp_gp [GRP_N];
    logic [GRP_N-1:0] grp_g;
    logic [GRP_N-1:0] grp_p;
    logic [GRP_N-1:0] grp_cin;
    logic [GRP_N-1:1] lvl2_c;
    gp_t              word_gp;

    for (genvar k = 0; k < GRP_N; k++) begin : g_grp
        cla16_group i_grp (
            .a_sl (op_a[k*GRP_W +: GRP_W]),
            .b_sl (op_b[k*GRP_W +: GRP_W]),
            .c_in (grp_cin[k]),
            .s_sl (sum[k*GRP_W +: GRP_W]),
            .grp  (grp_gp[k])
        );
        assign grp_g[k] = grp_gp[k].gen;
        assign grp_p[k] = grp_gp[k].prop;
    end

    // Second level: the same flattened form, applied to the group pairs.
    cla16_lookahead #(.N(GRP_N)) i_lvl2 (
        .g_vec (grp_g),
        .p_vec (grp_p),
        .c_in  (carry_in),
        .c_mid (lvl2_c),
        .blk   (word_gp)
    );

    assign grp_cin[0]         = carry_in;
    assign grp_cin[GRP_N-1:1] = lvl2_c;

    assign word_gen  = word_gp.gen;
    assign word_prop = word_gp.prop;
    assign carry_out = word_gp.gen | (word_gp.prop & carry_in);

endmodule

// File: rtl/cla16_adder_chk.sv
module cla16_adder_chk (
    input logic [15:0] op_a,
    input logic [15:0] op_b,
    input logic        carry_in,
    input logic [15:0] sum,
    input logic        carry_out,
    input logic        word_gen,
    input logic        word_prop
);

    logic [16:0] full_ref;
    logic [16:0] nocin_ref;

    always_comb begin
        full_ref  = {1'b0, op_a} + {1'b0, op_b} + {16'd0, carry_in};
        nocin_ref = {1'b0, op_a} + {1'b0, op_b};
        AST_SUM_MATCH:   assert (sum == full_ref[15:0]);                          // R1
        AST_CARRY_MATCH: assert (carry_out == full_ref[16]);                      // R2
        AST_GEN_WORD:    assert (word_gen == nocin_ref[16]);                      // R3
        AST_PROP_WORD:   assert (word_prop == ((op_a | op_b) == 16'hFFFF));       // R4
        AST_GEN_FORCES:  assert (!word_gen || carry_out);                         // R5
        AST_PROP_PASSES: assert (word_gen || !word_prop || carry_out == carry_in); // R6
    end

endmodule

bind cla16_adder cla16_adder_chk i_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum       (sum),
    .carry_out (carry_out),
    .word_gen  (word_gen),
    .word_prop (word_prop)
);

// File: tb/test_cla16_adder.sv
module test_cla16_adder;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk;
    logic [15:0] op_a;
    logic [15:0] op_b;
    logic        carry_in;
    logic [15:0] sum;
    logic        carry_out;
    logic        word_gen;
    logic        word_prop;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    cla16_adder i_cla16_adder (
        .op_a      (op_a),
        .op_b      (op_b),
        .carry_in  (carry_in),
        .sum       (sum),
        .carry_out (carry_out),
        .word_gen  (word_gen),
        .word_prop (word_prop)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic expect_bit(input string tag, input logic got, input logic want);
        total++;
        if (got !== want) begin
            bad++;
            $display("FAIL %s got=%0b expected=%0b", tag, got, want);
        end
    endtask

    task automatic apply_and_check(input logic [15:0] a, input logic [15:0] b, input logic ci);
        logic [16:0] ref_full;
        logic [16:0] ref_nocin;
        logic        ref_p;
        op_a     = a;
        op_b     = b;
        carry_in = ci;
        @(negedge clk);
        ref_full  = {1'b0, a} + {1'b0, b} + {16'd0, ci};
        ref_nocin = {1'b0, a} + {1'b0, b};
        ref_p     = ((a | b) == 16'hFFFF);
        total++;
        if (sum !== ref_full[15:0]) begin
            bad++;
            $display("FAIL R1 a=%h b=%h ci=%0b sum got=%h expected=%h", a, b, ci, sum, ref_full[15:0]);
        end
        expect_bit("R2 carry_out", carry_out, ref_full[16]);
        expect_bit("R3 word_gen", word_gen, ref_nocin[16]);
        expect_bit("R4 word_prop", word_prop, ref_p);
        if (ref_nocin[16]) expect_bit("R5 generate forces carry", carry_out, 1'b1);
        if (!ref_nocin[16] && ref_p) expect_bit("R6 propagate passes carry", carry_out, ci);
    endtask

    task automatic t_idle;
        apply_and_check(16'h0000, 16'h0000, 1'b0); // R1 R2 R3 R4 all zero
    endtask

    task automatic t_full_ripple; // R7
        apply_and_check(16'hFFFF, 16'h0000, 1'b1);
        total++;
        if (sum !== 16'h0000 || carry_out !== 1'b1) begin
            bad++;
            $display("FAIL R7 sum=%h cout=%0b expected=0000 1", sum, carry_out);
        end
        apply_and_check(16'h0000, 16'hFFFF, 1'b1);
        apply_and_check(16'hFFFF, 16'hFFFF, 1'b1);
        apply_and_check(16'hFFFF, 16'hFFFF, 1'b0);
        apply_and_check(16'hA5A5, 16'h5A5A, 1'b0); // R6 propagate only
        apply_and_check(16'hA5A5, 16'h5A5A, 1'b1);
    endtask

    task automatic t_group_cross; // R8
        apply_and_check(16'h000F, 16'h0001, 1'b0);
        total++;
        if (sum !== 16'h0010) begin
            bad++;
            $display("FAIL R8 sum=%h expected=0010", sum);
        end
        apply_and_check(16'h0FFF, 16'h0001, 1'b0);
        total++;
        if (sum !== 16'h1000) begin
            bad++;
            $display("FAIL R8 sum=%h expected=1000", sum);
        end
        for (int k = 0; k < 4; k++) begin
            for (int ci = 0; ci < 2; ci++) begin
                logic [15:0] hi_prop;
                hi_prop = 16'hFFFF << (4 * (k + 1));
                apply_and_check(hi_prop | (16'h0008 << (4 * k)), 16'h0008 << (4 * k), ci[0]);
                apply_and_check(hi_prop, 16'h0000, ci[0]);
            end
        end
    endtask

    task automatic t_walk; // R1 R2 single bits
        for (int i = 0; i < 16; i++) begin
            apply_and_check(16'h0001 << i, 16'h0001 << i, 1'b0);
            apply_and_check(~(16'h0001 << i), 16'h0001 << i, 1'b1);
        end
    endtask

    task automatic t_random; // R1 R2 R3 R4 R5 R6
        for (int n = 0; n < 2000; n++) begin
            logic [15:0] ra;
            logic [15:0] rb;
            ra = 16'($urandom);
            rb = 16'($urandom);
            if (n % 4 == 0) rb = ~ra;
            apply_and_check(ra, rb, 1'($urandom));
        end
    endtask

    initial begin
        op_a = '0;
        op_b = '0;
        carry_in = 1'b0;
        repeat (2) @(negedge clk);
        t_idle();
        t_full_ripple();
        t_group_cross();
        t_walk();
        t_random();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule